// File: doc/BRIEF.md
# Hub-Execution Instruction Line Cache

This block sits between a processor core that runs code out of a shared hub memory and the hub's wide-read port. It keeps four lines of eight 32-bit instructions each. A fetch that hits returns its instruction in the same cycle. A fetch that misses stalls the core while one whole eight-long wide is read from the hub into a line.

To hide hub latency, two mechanisms fill lines ahead of use. The cache follows a demand fill with a fetch of the next sequential wide. Each time execution first enters a line that was loaded ahead of time, it requests the wide after that line. Software can also order one to three consecutive wides to be loaded from a given wide address.

Explicit data reads from the core always take the hub port ahead of any instruction fill. In single-task mode the four lines are shared and replaced in least-recently-used order. In multi-task mode each of four tasks owns one line, and no filling ahead takes place. The mode input is set while reset is held and stays constant afterwards.

Top module: `icache_hubexec`

## Requirements
- R1: After reset no line is valid. Every valid fetch stalls, and `hub_req` stays low until a fetch misses or a prefetch is ordered.
- R2: When a fetch hits, `fetch_stall` is low in the same cycle. `fetch_instr` then equals long `fetch_addr[2:0]` of the resident wide, where long i of the wide occupies bits `hub_wide[32*i+31:32*i]`.
- R3: On a miss, `fetch_stall` is high and, one cycle later, `hub_req` rises with `hub_addr = fetch_addr >> 3`. The line becomes usable only in the cycle after the cycle in which `hub_req` and `hub_gnt` are both high.
- R4: In single-task mode a fill replaces the least recently used line. The order after reset is line 0 oldest through line 3 newest, and every fill and every hit makes its line the newest. A wide is never held in two lines.
- R5: In single-task mode, after a demand fill of wide W completes, the cache requests wide W+1 without any further fetch.
- R6: The first hit into a line that was filled ahead of use triggers a request for the wide after it.
- R7: A prefetch command with wide address A and count N (1, 2 or 3) requests wides A to A+N-1 in rising order. Wides that are already resident are skipped. A count of 0 has no effect.
- R8: While `data_rd_req` is high, `hub_req` is low. The pending request is kept and is presented again, unchanged, once `data_rd_req` falls.
- R9: Only one request is outstanding at a time, and `hub_addr` holds steady until it is granted. A miss on the wide that is already being fetched waits for that fill and causes no second request.
- R10: In multi-task mode, task t (`fetch_task`) fills and hits only line t. No next-line or commanded prefetch is requested.
- R11: When the hub port is free and a demand miss and a prefetch are both pending, the demand miss is issued first. Commanded prefetches go ahead of the automatic next-line prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| multi_mode | input | 1 | 1: one fixed line per task; 0: four shared lines under LRU |
| fetch_valid | input | 1 | Core presents an instruction fetch |
| fetch_addr | input | ADDR_W | Long address of the fetch |
| fetch_task | input | 2 | Task issuing the fetch (used in multi-task mode) |
| fetch_instr | output | DATA_W | Instruction returned on a hit |
| fetch_stall | output | 1 | Fetch missed; core must hold |
| data_rd_req | input | 1 | Explicit data read wants the hub port |
| pf_cmd_valid | input | 1 | Software prefetch command strobe |
| pf_cmd_wide | input | ADDR_W-3 | First wide address to prefetch |
| pf_cmd_count | input | 2 | Number of wides to prefetch (1..3, 0 ignored) |
| hub_req | output | 1 | Wide-read request to the hub |
| hub_addr | output | ADDR_W-3 | Wide address of the request |
| hub_gnt | input | 1 | Hub delivers the wide this cycle |
| hub_wide | input | 8*DATA_W | Eight longs of the granted wide |

## Verification
The embedded properties watch, on every cycle, that the hub address holds steady while a request waits, that a pending request survives a data-read hold-off, and that the recency list stays a permutation of the four lines. They also check that no wide is resident twice in single-task mode, that a just-granted wide hits on the next cycle, and that multi-task mode only ever asks for demand fills. Only the directed scenarios can show which line a fill evicts, the exact order of demand, commanded and automatic requests, and the skipping of wides that are already resident. The same holds for the absence of a duplicate request when a miss lands on a wide that is still in flight, and for task isolation in multi-task mode.

// File: rtl/icache_pkg.sv
package icache_pkg;

  // Origin of a hub request; decides whether the filled line is marked as
  // "loaded ahead of use".
  typedef enum logic [1:0] {
    KIND_DEMAND = 2'd0,
    KIND_SOFT   = 2'd1,
    KIND_AUTO   = 2'd2
  } fill_kind_e;

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int LINES = 4,
  parameter int TAG_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic                     wr_mark,
  input  logic                     clr_en,
  input  logic [$clog2(LINES)-1:0] clr_idx,
  input  logic [TAG_W-1:0]         cmp_a,
  input  logic [TAG_W-1:0]         cmp_b,
  output logic [LINES-1:0]         hit_a,
  output logic [LINES-1:0]         hit_b,
  output logic [LINES-1:0]         mark
);
  localparam int IDX_W = $clog2(LINES);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    logic             vld_q, vld_d;
    logic             mrk_q, mrk_d;
    logic             load;

    always_comb begin
      load  = wr_en && (wr_idx == IDX_W'(g));
      vld_d = vld_q;
      mrk_d = mrk_q;
      if (load) begin
        vld_d = 1'b1;
        mrk_d = wr_mark;
      end else if (clr_en && (clr_idx == IDX_W'(g))) begin
        mrk_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        mrk_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        mrk_q <= mrk_d;
      end
    end

    always_ff @(posedge clk) begin
      if (load) tag_q <= wr_tag;
    end

    assign hit_a[g] = vld_q && (tag_q == cmp_a);
    assign hit_b[g] = vld_q && (tag_q == cmp_b);
    assign mark[g]  = vld_q && mrk_q;
  end

endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int LINES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ta_en,
  input  logic [$clog2(LINES)-1:0] ta_idx,
  input  logic                     tb_en,
  input  logic [$clog2(LINES)-1:0] tb_idx,
  output logic [$clog2(LINES)-1:0] victim
);
  localparam int IDX_W = $clog2(LINES);
  typedef logic [LINES-1:0][IDX_W-1:0] ord_t;

  // Entry 0 is the oldest line, entry LINES-1 the newest.
  ord_t ord_q, ord_d;

  function automatic ord_t promote(ord_t o, logic [IDX_W-1:0] id);
    ord_t r;
    logic found;
    r     = o;
    found = 1'b0;
    for (int i = 0; i < LINES - 1; i++) begin
      if (o[i] == id) found = 1'b1;
      if (found) r[i] = o[i+1];
    end
    r[LINES-1] = id;
    return r;
  endfunction

  always_comb begin
    ord_d = ord_q;
    if (ta_en) ord_d = promote(ord_d, ta_idx);
    if (tb_en) ord_d = promote(ord_d, tb_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) ord_q[i] <= IDX_W'(i);
    end else begin
      ord_q <= ord_d;
    end
  end

  assign victim = ord_q[0];

  logic [LINES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < LINES; i++) seen[ord_q[i]] = 1'b1;
  end

  // R4
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) (&seen))
    else $error("recency list lost a line");

endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int LINES  = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(LINES)-1:0]     wr_idx,
  input  logic [WORDS*DATA_W-1:0]      wr_wide,
  input  logic [$clog2(LINES)-1:0]     rd_idx,
  input  logic [$clog2(WORDS)-1:0]     rd_word,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINE_W-1:0] line_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) line_q[g] <= wr_wide;
    end
  end

  assign rd_data = line_q[rd_idx][rd_word*DATA_W +: DATA_W];

endmodule

// File: rtl/icache_fill.sv
module icache_fill
  import icache_pkg::*;
#(
  parameter int WIDE_W = 13,
  parameter int TASK_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              multi_mode,
  input  logic              data_rd_req,
  input  logic              dem_miss,
  input  logic [WIDE_W-1:0] dem_wide,
  input  logic [TASK_W-1:0] dem_task,
  input  logic              pf_cmd_valid,
  input  logic [WIDE_W-1:0] pf_cmd_wide,
  input  logic [CNT_W-1:0]  pf_cmd_count,
  input  logic              mark_hit,
  input  logic [WIDE_W-1:0] mark_wide,
  output logic [WIDE_W-1:0] probe_wide,
  input  logic              probe_hit,
  output logic              hub_req,
  output logic [WIDE_W-1:0] hub_addr,
  input  logic              hub_gnt,
  output logic              fill_en,
  output logic [WIDE_W-1:0] fill_wide,
  output fill_kind_e        fill_kind,
  output logic [TASK_W-1:0] fill_task
);
  // In-flight request
  logic              busy_q, busy_d;
  logic [WIDE_W-1:0] wide_q, wide_d;
  fill_kind_e        kind_q, kind_d;
  logic [TASK_W-1:0] task_q, task_d;
  // Commanded prefetch run
  logic [CNT_W-1:0]  swc_q, swc_d;
  logic [WIDE_W-1:0] sww_q, sww_d;
  // Automatic next-line prefetch
  logic              apv_q, apv_d;
  logic [WIDE_W-1:0] apw_q, apw_d;

  logic gnt, use_sw, pf_pend;

  always_comb begin
    busy_d = busy_q;
    wide_d = wide_q;
    kind_d = kind_q;
    task_d = task_q;
    swc_d  = swc_q;
    sww_d  = sww_q;
    apv_d  = apv_q;
    apw_d  = apw_q;

    gnt        = busy_q && !data_rd_req && hub_gnt;
    use_sw     = (swc_q != '0);
    pf_pend    = !multi_mode && (use_sw || apv_q);
    probe_wide = use_sw ? sww_q : apw_q;

    if (gnt) busy_d = 1'b0;

    if (!busy_q) begin
      if (dem_miss) begin
        busy_d = 1'b1;
        wide_d = dem_wide;
        kind_d = KIND_DEMAND;
        task_d = dem_task;
      end else if (pf_pend) begin
        if (!probe_hit) begin
          busy_d = 1'b1;
          wide_d = probe_wide;
          kind_d = use_sw ? KIND_SOFT : KIND_AUTO;
          task_d = '0;
        end
        if (use_sw) begin
          swc_d = swc_q - CNT_W'(1);
          sww_d = sww_q + WIDE_W'(1);
        end else begin
          apv_d = 1'b0;
        end
      end
    end

    if (gnt && (kind_q == KIND_DEMAND) && !multi_mode) begin
      apv_d = 1'b1;
      apw_d = wide_q + WIDE_W'(1);
    end else if (mark_hit && !multi_mode) begin
      apv_d = 1'b1;
      apw_d = mark_wide;
    end

    if (pf_cmd_valid && !multi_mode && (pf_cmd_count != '0)) begin
      swc_d = pf_cmd_count;
      sww_d = pf_cmd_wide;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wide_q <= '0;
      kind_q <= KIND_DEMAND;
      task_q <= '0;
      swc_q  <= '0;
      sww_q  <= '0;
      apv_q  <= 1'b0;
      apw_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wide_q <= wide_d;
      kind_q <= kind_d;
      task_q <= task_d;
      swc_q  <= swc_d;
      sww_q  <= sww_d;
      apv_q  <= apv_d;
      apw_q  <= apw_d;
    end
  end

  assign hub_req   = busy_q && !data_rd_req;
  assign hub_addr  = wide_q;
  assign fill_en   = gnt;
  assign fill_wide = wide_q;
  assign fill_kind = kind_q;
  assign fill_task = task_q;

  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hub_req) |=> busy_q)
    else $error("request dropped during data-read hold-off");

endmodule

// File: rtl/icache_hubexec.sv
module icache_hubexec
  import icache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 8,
  parameter int CNT_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      multi_mode,
  input  logic                      fetch_valid,
  input  logic [ADDR_W-1:0]         fetch_addr,
  input  logic [$clog2(LINES)-1:0]  fetch_task,
  output logic [DATA_W-1:0]         fetch_instr,
  output logic                      fetch_stall,
  input  logic                      data_rd_req,
  input  logic                      pf_cmd_valid,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] pf_cmd_wide,
  input  logic [CNT_W-1:0]          pf_cmd_count,
  output logic                      hub_req,
  output logic [ADDR_W-$clog2(WORDS)-1:0] hub_addr,
  input  logic                      hub_gnt,
  input  logic [WORDS*DATA_W-1:0]   hub_wide
);
  localparam int OFS_W  = $clog2(WORDS);
  localparam int WIDE_W = ADDR_W - OFS_W;
  localparam int IDX_W  = $clog2(LINES);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic [WIDE_W-1:0] fetch_wide;
  logic [OFS_W-1:0]  fetch_ofs;
  assign fetch_wide = fetch_addr[ADDR_W-1:OFS_W];
  assign fetch_ofs  = fetch_addr[OFS_W-1:0];

  logic [LINES-1:0]  hit_raw, hit_vec, probe_vec, mark_vec, lane_mask;
  logic              hit, mark_hit, probe_hit;
  logic [IDX_W-1:0]  hit_line, victim, fill_line, fill_task;
  logic [WIDE_W-1:0] probe_wide, fill_wide;
  logic              fill_en;
  fill_kind_e        fill_kind;

  always_comb begin
    lane_mask = multi_mode ? (LINES'(1) << fetch_task) : '1;
    hit_vec   = hit_raw & lane_mask;
    hit       = |hit_vec;
    hit_line  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_line = IDX_W'(i);
    end
    mark_hit  = fetch_valid && hit && !multi_mode && mark_vec[hit_line];
    probe_hit = |probe_vec;
    fill_line = multi_mode ? fill_task : victim;
  end

  assign fetch_stall = fetch_valid && !hit;

  icache_tags #(.LINES(LINES), .TAG_W(WIDE_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (fill_en),
    .wr_idx  (fill_line),
    .wr_tag  (fill_wide),
    .wr_mark (fill_kind != KIND_DEMAND),
    .clr_en  (mark_hit),
    .clr_idx (hit_line),
    .cmp_a   (fetch_wide),
    .cmp_b   (probe_wide),
    .hit_a   (hit_raw),
    .hit_b   (probe_vec),
    .mark    (mark_vec)
  );

  icache_lru #(.LINES(LINES)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .ta_en  (fill_en),
    .ta_idx (fill_line),
    .tb_en  (fetch_valid && hit),
    .tb_idx (hit_line),
    .victim (victim)
  );

  icache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_idx  (fill_line),
    .wr_wide (hub_wide),
    .rd_idx  (hit_line),
    .rd_word (fetch_ofs),
    .rd_data (fetch_instr)
  );

  icache_fill #(.WIDE_W(WIDE_W), .TASK_W(IDX_W), .CNT_W(CNT_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .multi_mode   (multi_mode),
    .data_rd_req  (data_rd_req),
    .dem_miss     (fetch_stall),
    .dem_wide     (fetch_wide),
    .dem_task     (fetch_task),
    .pf_cmd_valid (pf_cmd_valid),
    .pf_cmd_wide  (pf_cmd_wide),
    .pf_cmd_count (pf_cmd_count),
    .mark_hit     (mark_hit),
    .mark_wide    (fetch_wide + WIDE_W'(1)),
    .probe_wide   (probe_wide),
    .probe_hit    (probe_hit),
    .hub_req      (hub_req),
    .hub_addr     (hub_addr),
    .hub_gnt      (hub_gnt),
    .fill_en      (fill_en),
    .fill_wide    (fill_wide),
    .fill_kind    (fill_kind),
    .fill_task    (fill_task)
  );

  // R4
  one_copy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !multi_mode |-> $onehot0(hit_raw))
    else $error("wide resident in two lines");

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hub_req && hub_gnt && !multi_mode) ##1 (fetch_valid && (fetch_wide == $past(hub_addr)))
      |-> !fetch_stall)
    else $error("granted wide did not hit");

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hub_req && !hub_gnt) |=> (hub_addr == $past(hub_addr)))
    else $error("hub address moved before grant");

  // R10
  multi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (multi_mode && hub_req) |-> (fill_kind == KIND_DEMAND))
    else $error("prefetch issued in multi-task mode");

endmodule

// File: tb/sim_icache_hubexec.sv
`timescale 1ns/1ps
module sim_icache_hubexec;
  localparam int ADDR_W = 16;
  localparam int WIDE_W = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        multi_mode;
  logic        fetch_valid;
  logic [15:0] fetch_addr;
  logic [1:0]  fetch_task;
  logic [31:0] fetch_instr;
  logic        fetch_stall;
  logic        data_rd_req;
  logic        pf_cmd_valid;
  logic [12:0] pf_cmd_wide;
  logic [1:0]  pf_cmd_count;
  logic        hub_req;
  logic [12:0] hub_addr;
  logic        hub_gnt;
  logic [255:0] hub_wide;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  icache_hubexec u0 (
    .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_task(fetch_task),
    .fetch_instr(fetch_instr), .fetch_stall(fetch_stall),
    .data_rd_req(data_rd_req), .pf_cmd_valid(pf_cmd_valid),
    .pf_cmd_wide(pf_cmd_wide), .pf_cmd_count(pf_cmd_count),
    .hub_req(hub_req), .hub_addr(hub_addr), .hub_gnt(hub_gnt), .hub_wide(hub_wide)
  );

  function automatic logic [31:0] mk(int w, int i);
    return 32'h5A00_0000 | (32'(w) << 4) | 32'(i);
  endfunction

  function automatic logic [255:0] mkwide(logic [12:0] w);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = mk(int'(w), i);
    return r;
  endfunction

  function automatic logic [15:0] la(int w, int i);
    return 16'(w * 8 + i);
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below 50000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; multi_mode = mode; fetch_valid = 1'b0; fetch_addr = '0;
    fetch_task = '0; data_rd_req = 1'b0; pf_cmd_valid = 1'b0; pf_cmd_wide = '0;
    pf_cmd_count = '0; hub_gnt = 1'b0; hub_wide = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic wait_req(int exp, string tag);
    int n = 0;
    #1;
    while (!hub_req && n < 12) begin
      step();
      n++;
    end
    chk(tag, 32'(hub_req), 32'd1);
    chk(tag, 32'(hub_addr), 32'(exp));
  endtask

  task automatic grant;
    hub_gnt  = 1'b1;
    hub_wide = mkwide(hub_addr);
    step();
    hub_gnt  = 1'b0;
  endtask

  task automatic quiet(int n, string tag);
    for (int k = 0; k < n; k++) begin
      step();
      chk(tag, 32'(hub_req), 32'd0);
    end
  endtask

  task automatic soft_cmd(int w, int cnt);
    pf_cmd_valid = 1'b1; pf_cmd_wide = 13'(w); pf_cmd_count = 2'(cnt);
    step();
    pf_cmd_valid = 1'b0;
  endtask

  // R1: empty after reset
  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 idle req", 32'(hub_req), 32'd0);
    fetch_valid = 1'b1; fetch_addr = la(0, 0); #1;
    chk("R1 empty stall", 32'(fetch_stall), 32'd1);
  endtask

  // R2 R3 R5 R6: miss, fill, hit, next-line chain
  task automatic t_miss_hit;
    do_reset(1'b0);
    fetch_valid = 1'b1; fetch_addr = la(5, 3); #1;
    chk("R3 miss stall", 32'(fetch_stall), 32'd1);
    chk("R3 req next cycle", 32'(hub_req), 32'd0);
    step();
    chk("R3 req", 32'(hub_req), 32'd1);
    chk("R3 addr", 32'(hub_addr), 32'd5);
    chk("R3 stall held", 32'(fetch_stall), 32'd1);
    grant(); #1;
    chk("R3 stall released", 32'(fetch_stall), 32'd0);
    chk("R2 instr", fetch_instr, mk(5, 3));
    fetch_addr = la(5, 7); #1;
    chk("R2 other word", fetch_instr, mk(5, 7));
    wait_req(6, "R5 next wide");
    grant();
    fetch_addr = la(6, 0); #1;
    chk("R6 prefetched hit", 32'(fetch_stall), 32'd0);
    chk("R6 prefetched instr", fetch_instr, mk(6, 0));
    wait_req(7, "R6 chained wide");
    grant();
  endtask

  // R9: miss on the wide already in flight
  task automatic t_same_wide;
    do_reset(1'b0);
    fetch_valid = 1'b1; fetch_addr = la(20, 0);
    wait_req(20, "R3 demand");
    grant();
    wait_req(21, "R5 next wide");
    fetch_addr = la(21, 2); #1;
    chk("R9 stall on inflight", 32'(fetch_stall), 32'd1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 single req", 32'(hub_req), 32'd1);
      chk("R9 addr held", 32'(hub_addr), 32'd21);
    end
    grant(); #1;
    chk("R9 hit after fill", 32'(fetch_stall), 32'd0);
    chk("R9 instr", fetch_instr, mk(21, 2));
    wait_req(22, "R9 no duplicate");
    grant();
  endtask

  // R8: data reads hold instruction fills off
  task automatic t_data_pri;
    do_reset(1'b0);
    fetch_valid = 1'b1; fetch_addr = la(30, 1);
    wait_req(30, "R3 demand");
    data_rd_req = 1'b1; #1;
    chk("R8 yield", 32'(hub_req), 32'd0);
    step();
    chk("R8 still yield", 32'(hub_req), 32'd0);
    chk("R8 core stalled", 32'(fetch_stall), 32'd1);
    data_rd_req = 1'b0; #1;
    chk("R8 resume", 32'(hub_req), 32'd1);
    chk("R8 same addr", 32'(hub_addr), 32'd30);
    grant(); #1;
    chk("R8 hit", 32'(fetch_stall), 32'd0);
  endtask

  // R7: commanded prefetch runs
  task automatic t_soft;
    do_reset(1'b0);
    soft_cmd(40, 3);
    wait_req(40, "R7 first");  grant();
    wait_req(41, "R7 second"); grant();
    wait_req(42, "R7 third");  grant();
    quiet(4, "R7 run ends");
    soft_cmd(80, 0);
    quiet(4, "R7 zero count");
    fetch_valid = 1'b1; fetch_addr = la(41, 1); #1;
    chk("R7 resident", 32'(fetch_stall), 32'd0);
    chk("R7 instr", fetch_instr, mk(41, 1));
    quiet(4, "R7 resident next skipped");
    fetch_valid = 1'b0;
    soft_cmd(42, 2);
    wait_req(43, "R7 skip resident");
    grant();
    quiet(3, "R7 run ends");
  endtask

  // R11: issue order
  task automatic t_prio;
    do_reset(1'b0);
    soft_cmd(60, 2);
    wait_req(60, "R7 first");
    fetch_valid = 1'b1; fetch_addr = la(70, 4);
    grant();
    wait_req(70, "R11 demand first");
    grant(); #1;
    chk("R3 demand hit", fetch_instr, mk(70, 4));
    wait_req(61, "R11 command before auto");
    grant();
    wait_req(71, "R11 auto last");
    grant();
  endtask

  // R4: LRU victim choice
  task automatic t_lru;
    do_reset(1'b0);
    fetch_valid = 1'b1; fetch_addr = la(10, 0);
    wait_req(10, "R4 fill"); grant();
    wait_req(11, "R5");      grant();
    fetch_addr = la(20, 0);
    wait_req(20, "R4 fill"); grant();
    wait_req(21, "R5");      grant();
    fetch_addr = la(10, 0); #1;
    chk("R4 10 hit", 32'(fetch_stall), 32'd0);
    step();
    fetch_addr = la(50, 0);
    wait_req(50, "R4 fill"); grant();
    wait_req(51, "R5");      grant();
    fetch_addr = la(10, 1); #1;
    chk("R4 10 kept", 32'(fetch_stall), 32'd0);
    chk("R4 10 instr", fetch_instr, mk(10, 1));
    fetch_addr = la(20, 1); #1;
    chk("R4 20 kept", 32'(fetch_stall), 32'd0);
    step();
    fetch_addr = la(11, 0); #1;
    chk("R4 11 evicted", 32'(fetch_stall), 32'd1);
    step();
    fetch_addr = la(21, 0); #1;
    chk("R4 21 evicted", 32'(fetch_stall), 32'd1);
    fetch_valid = 1'b0;
  endtask

  // R10: one fixed line per task
  task automatic t_multi;
    do_reset(1'b1);
    fetch_valid = 1'b1; fetch_task = 2'd0; fetch_addr = la(10, 2);
    wait_req(10, "R10 task0"); grant(); #1;
    chk("R10 task0 hit", fetch_instr, mk(10, 2));
    quiet(4, "R10 no auto prefetch");
    fetch_task = 2'd1; #1;
    chk("R10 other task misses", 32'(fetch_stall), 32'd1);
    wait_req(10, "R10 task1"); grant();
    fetch_task = 2'd0; fetch_addr = la(30, 0);
    wait_req(30, "R10 task0 refill"); grant();
    fetch_task = 2'd1; fetch_addr = la(10, 5); #1;
    chk("R10 task1 kept", 32'(fetch_stall), 32'd0);
    chk("R10 task1 instr", fetch_instr, mk(10, 5));
    fetch_task = 2'd0; fetch_addr = la(10, 0); #1;
    chk("R10 task0 replaced", 32'(fetch_stall), 32'd1);
    fetch_valid = 1'b0;
    step();
    soft_cmd(90, 3);
    quiet(4, "R10 command ignored");
  endtask

  initial begin
    t_reset();
    t_miss_hit();
    t_same_wide();
    t_data_pri();
    t_soft();
    t_prio();
    t_lru();
    t_multi();
    summary();
    $finish;
  end

endmodule